// File: doc/BRIEF.md
# Mailbox Interrupt Flag Logic

This block sits next to a 4K x 16 two-port memory and lets each side notify the other through a mailbox word. Two addresses at the top of the space act as mailboxes. When port B writes the word just below the top, port A's interrupt flag goes active. When port A writes the top word, port B's flag goes active. The receiving side acknowledges by reading or writing its own mailbox word, and that clears its flag.

The block only looks at each port's enable, output enable, write strobe, address and busy input. It never sees the data, so the two mailbox words stay ordinary storage that software may use as normal memory when the interrupts are not needed. The block is synchronous and registered: a qualifying access sampled on one rising edge shows on the flag after that same edge. A synchronous active-high reset puts both flags into their inactive state.

Top module: `mbx_irq_flags`

## Requirements
- R1: While `rst` is high at a rising edge, both `a_irq_n` and `b_irq_n` are 1 (inactive) after that edge.
- R2: A port B write (`b_en`=1 and `b_wr`=1) to address 0xFFE with `b_busy_n`=1 makes `a_irq_n` 0 after that edge.
- R3: A port A write (`a_en`=1 and `a_wr`=1) to address 0xFFF with `a_busy_n`=1 makes `b_irq_n` 0 after that edge.
- R4: Port A clears `a_irq_n` to 1 by accessing 0xFFE, either a read (`a_en`=1, `a_oe`=1) or a write (`a_en`=1, `a_wr`=1), with `a_busy_n`=1; port B clears `b_irq_n` the same way at 0xFFF.
- R5: An access counts only with its port's enable high: a strobe without enable, or enable without strobe and without output enable, neither sets nor clears a flag.
- R6: When the acting port's busy input is 0, its set or clear attempt leaves the flag unchanged.
- R7: When a set and a clear of the same flag arrive at the same edge, the flag becomes 0 (active).
- R8: Accesses to any other address, or to the other side's mailbox by a port for clearing, or to its own mailbox by a port for setting, leave both flags unchanged; a flag holds its value when no qualifying access occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_en | input | 1 | Port A enable, active high |
| a_oe | input | 1 | Port A output (read) enable, active high |
| a_wr | input | 1 | Port A write strobe, active high |
| a_busy_n | input | 1 | Port A busy, low inhibits A's flag actions |
| a_addr | input | 12 | Port A word address |
| b_en | input | 1 | Port B enable, active high |
| b_oe | input | 1 | Port B output (read) enable, active high |
| b_wr | input | 1 | Port B write strobe, active high |
| b_busy_n | input | 1 | Port B busy, low inhibits B's flag actions |
| b_addr | input | 12 | Port B word address |
| a_irq_n | output | 1 | Interrupt to port A, active low |
| b_irq_n | output | 1 | Interrupt to port B, active low |

## Verification
A flag register holding the wrong value is visible directly on its interrupt pin, one edge after the access that should have produced it, because each flag is a single register driven straight to the port. A decoder fault, such as a swapped mailbox address, a missing enable term or an ignored busy input, shows as a flag that either falls or rises one cycle after an access that should have left it alone, or that fails to move after one that should move it. The bench therefore compares both pins after every edge against a reference built from the rules, which pins any such error to the exact cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Number of sides sharing the memory
    localparam int unsigned NSIDE = 2;

    // Events produced by one side's decoder
    typedef struct packed {
        logic post;  // write into the peer's mailbox word
        logic take;  // read or write of the own mailbox word
    } side_evt_t;

    // Mailbox word owned by a side: side 0 owns top-1, side 1 owns top
    function automatic logic [31:0] mbox_addr(input int unsigned aw, input int unsigned side);
        logic [31:0] top;
        top = (32'd1 << aw) - 32'd1;
        return top - 32'd1 + 32'(side);
    endfunction

endpackage

// File: rtl/mbx_side_dec.sv
module mbx_side_dec
    import mbx_pkg::*;
#(
    parameter int unsigned          ADDR_W   = 12,
    parameter logic [ADDR_W-1:0]    OWN_BOX  = '0,
    parameter logic [ADDR_W-1:0]    PEER_BOX = '0
) (
    input  logic              en,
    input  logic              oe,
    input  logic              wr,
    input  logic              busy_n,
    input  logic [ADDR_W-1:0] addr,
    output side_evt_t         evt
);

    logic wr_cyc;
    logic any_cyc;

    always_comb begin
        wr_cyc   = en & wr & busy_n;
        any_cyc  = en & (oe | wr) & busy_n;
        evt.post = wr_cyc  & (addr == PEER_BOX);
        evt.take = any_cyc & (addr == OWN_BOX);
    end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag_n
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_n <= 1'b1;
        end else if (set) begin
            flag_n <= 1'b0;   // set wins so no message is dropped
        end else if (clr) begin
            flag_n <= 1'b1;
        end
    end

endmodule

// File: rtl/mbx_irq_flags.sv
module mbx_irq_flags
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_en,
    input  logic              a_oe,
    input  logic              a_wr,
    input  logic              a_busy_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_en,
    input  logic              b_oe,
    input  logic              b_wr,
    input  logic              b_busy_n,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              a_irq_n,
    output logic              b_irq_n
);

    logic [NSIDE-1:0]              en_v;
    logic [NSIDE-1:0]              oe_v;
    logic [NSIDE-1:0]              wr_v;
    logic [NSIDE-1:0]              bn_v;
    logic [NSIDE-1:0][ADDR_W-1:0]  ad_v;
    side_evt_t [NSIDE-1:0]         evt_v;
    logic [NSIDE-1:0]              irq_v;

    assign en_v = {b_en, a_en};
    assign oe_v = {b_oe, a_oe};
    assign wr_v = {b_wr, a_wr};
    assign bn_v = {b_busy_n, a_busy_n};
    assign ad_v = {b_addr, a_addr};

    for (genvar i = 0; i < NSIDE; i++) begin : g_side
        localparam int unsigned      PEER = NSIDE - 1 - i;
        localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(mbox_addr(ADDR_W, i));
        localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(mbox_addr(ADDR_W, PEER));

        mbx_side_dec #(
            .ADDR_W   (ADDR_W),
            .OWN_BOX  (OWN_A),
            .PEER_BOX (PEER_A)
        ) u_dec (
            .en     (en_v[i]),
            .oe     (oe_v[i]),
            .wr     (wr_v[i]),
            .busy_n (bn_v[i]),
            .addr   (ad_v[i]),
            .evt    (evt_v[i])
        );

        mbx_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .set    (evt_v[PEER].post),
            .clr    (evt_v[i].take),
            .flag_n (irq_v[i])
        );
    end

    assign a_irq_n = irq_v[0];
    assign b_irq_n = irq_v[1];

endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              a_en,
    input logic              a_oe,
    input logic              a_wr,
    input logic              a_busy_n,
    input logic [ADDR_W-1:0] a_addr,
    input logic              b_en,
    input logic              b_oe,
    input logic              b_wr,
    input logic              b_busy_n,
    input logic [ADDR_W-1:0] b_addr,
    input logic              a_irq_n,
    input logic              b_irq_n
);

    localparam logic [ADDR_W-1:0] TOP  = '1;
    localparam logic [ADDR_W-1:0] BOXA = TOP - 1'b1;

    logic set_a, set_b, clr_a, clr_b;
    assign set_a = b_en && b_wr && b_busy_n && (b_addr == BOXA);
    assign set_b = a_en && a_wr && a_busy_n && (a_addr == TOP);
    assign clr_a = a_en && (a_oe || a_wr) && a_busy_n && (a_addr == BOXA);
    assign clr_b = b_en && (b_oe || b_wr) && b_busy_n && (b_addr == TOP);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (a_irq_n && b_irq_n));

    // R7 also rests on these two: a set lands regardless of a clear
    assert_set_a_R2: assert property (@(posedge clk) disable iff (rst)
        set_a |=> !a_irq_n);

    assert_set_b_R3: assert property (@(posedge clk) disable iff (rst)
        set_b |=> !b_irq_n);

    assert_clear_a_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_a && !set_a) |=> a_irq_n);

    assert_clear_b_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_b && !set_b) |=> b_irq_n);

    // R5, R6, R8: without a qualified action a flag does not move
    assert_hold_a_R6: assert property (@(posedge clk) disable iff (rst)
        (!set_a && !clr_a) |=> $stable(a_irq_n));

    assert_hold_b_R8: assert property (@(posedge clk) disable iff (rst)
        (!set_b && !clr_b) |=> $stable(b_irq_n));

endmodule

bind mbx_irq_flags mbx_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_mbx_irq_flags.sv
module sim_mbx_irq_flags;

    typedef struct {
        logic en, oe, wr, bn;
        logic [11:0] ad;
    } pin_t;

    typedef struct {
        logic  a_n;
        logic  b_n;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_en = 0, a_oe = 0, a_wr = 0, a_busy_n = 1;
    logic b_en = 0, b_oe = 0, b_wr = 0, b_busy_n = 1;
    logic [11:0] a_addr = '0, b_addr = '0;
    logic a_irq_n, b_irq_n;

    int   n_run = 0;
    int   n_bad = 0;
    bit   done  = 0;
    logic ma = 1'b1, mb = 1'b1;
    exp_t sb[$];

    always #2 clk = ~clk;

    mbx_irq_flags u0 (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_oe(a_oe), .a_wr(a_wr), .a_busy_n(a_busy_n), .a_addr(a_addr),
        .b_en(b_en), .b_oe(b_oe), .b_wr(b_wr), .b_busy_n(b_busy_n), .b_addr(b_addr),
        .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
    );

    function automatic pin_t nop();
        pin_t p; p.en = 0; p.oe = 0; p.wr = 0; p.bn = 1; p.ad = 12'h000; return p;
    endfunction
    function automatic pin_t wrp(input logic [11:0] ad, input logic bn = 1'b1);
        pin_t p; p.en = 1; p.oe = 0; p.wr = 1; p.bn = bn; p.ad = ad; return p;
    endfunction
    function automatic pin_t rdp(input logic [11:0] ad, input logic bn = 1'b1);
        pin_t p; p.en = 1; p.oe = 1; p.wr = 0; p.bn = bn; p.ad = ad; return p;
    endfunction
    function automatic pin_t raw(input logic en, oe, wr, input logic [11:0] ad);
        pin_t p; p.en = en; p.oe = oe; p.wr = wr; p.bn = 1; p.ad = ad; return p;
    endfunction

    // Driver: apply one cycle of stimulus at the falling edge, push the expected flags
    task automatic step(input logic r, input pin_t a, input pin_t b, input string tag);
        exp_t e;
        logic sa, sbt, ca, cb;
        @(negedge clk);
        rst = r;
        a_en = a.en; a_oe = a.oe; a_wr = a.wr; a_busy_n = a.bn; a_addr = a.ad;
        b_en = b.en; b_oe = b.oe; b_wr = b.wr; b_busy_n = b.bn; b_addr = b.ad;
        sa  = b.en & b.wr & b.bn & (b.ad == 12'hFFE);
        sbt = a.en & a.wr & a.bn & (a.ad == 12'hFFF);
        ca  = a.en & (a.oe | a.wr) & a.bn & (a.ad == 12'hFFE);
        cb  = b.en & (b.oe | b.wr) & b.bn & (b.ad == 12'hFFF);
        if (r) begin
            ma = 1'b1; mb = 1'b1;
        end else begin
            if (sa) ma = 1'b0; else if (ca) ma = 1'b1;
            if (sbt) mb = 1'b0; else if (cb) mb = 1'b1;
        end
        e.a_n = ma; e.b_n = mb; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: one item per rising edge, compared just after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_run++;
                if (a_irq_n !== e.a_n || b_irq_n !== e.b_n) begin
                    n_bad++;
                    $display("FAIL %s: irq a/b = %b%b, expected %b%b",
                             e.tag, a_irq_n, b_irq_n, e.a_n, e.b_n);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(1, nop(), nop(), "R1 reset");
        step(1, nop(), nop(), "R1 reset");
        step(0, nop(), nop(), "R8 idle hold");
        // R2: B posts to A
        step(0, nop(), wrp(12'hFFE), "R2 B write FFE sets A");
        step(0, nop(), nop(), "R8 A flag holds");
        // R4: A clears by write, then by read
        step(0, wrp(12'hFFE), nop(), "R4 A write clears");
        step(0, nop(), wrp(12'hFFE), "R2 set again");
        step(0, raw(1, 0, 0, 12'hFFE), nop(), "R5 enable alone no clear");
        step(0, raw(0, 1, 1, 12'hFFE), nop(), "R5 no enable no clear");
        step(0, rdp(12'hFFE), nop(), "R4 A read clears");
        // R3: A posts to B, B clears by read
        step(0, wrp(12'hFFF), nop(), "R3 A write FFF sets B");
        step(0, nop(), rdp(12'hFFF), "R4 B read clears");
        // R5: strobe qualification on the sender
        step(0, raw(1, 1, 0, 12'hFFF), nop(), "R5 read is no post");
        step(0, raw(0, 0, 1, 12'hFFF), nop(), "R5 strobe without enable");
        step(0, nop(), raw(0, 0, 1, 12'hFFE), "R5 B strobe without enable");
        // R6: busy inhibits set and clear
        step(0, wrp(12'hFFF, 1'b0), nop(), "R6 busy blocks set");
        step(0, wrp(12'hFFF), nop(), "R3 set with busy high");
        step(0, nop(), rdp(12'hFFF, 1'b0), "R6 busy blocks clear");
        step(0, nop(), wrp(12'hFFF), "R4 B write clears");
        step(0, nop(), wrp(12'hFFE, 1'b0), "R6 busy blocks B post");
        // R7: set beats clear on the same edge
        step(0, rdp(12'hFFE), wrp(12'hFFE), "R7 set wins from idle");
        step(0, wrp(12'hFFE), wrp(12'hFFE), "R7 set wins while active");
        step(0, rdp(12'hFFE), nop(), "R4 clear after R7");
        // R8: wrong addresses
        step(0, wrp(12'hFFE), nop(), "R8 A write own box no post");
        step(0, nop(), wrp(12'hFFF), "R8 B write own box no post");
        step(0, wrp(12'h000), wrp(12'h7FF), "R8 other addresses");
        step(0, wrp(12'hFFD), wrp(12'hFFD), "R8 neighbour address");
        // both posted at once, then wrong side cannot clear
        step(0, wrp(12'hFFF), wrp(12'hFFE), "R2 R3 cross post");
        step(0, rdp(12'hFFF), rdp(12'hFFE), "R8 wrong box no clear");
        // R1: reset clears active flags
        step(1, nop(), nop(), "R1 reset from active");
        step(0, nop(), nop(), "R1 idle after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule